// File: doc/BRIEF.md
# Dual-Direction Serial Byte FIFO

This block sits between the register-bus side of a serial communication unit and its bit-level shift logic. It holds two byte queues. The transmit queue is filled by host writes and drained by the hardware, which loads the transmit shift register. The shift register then presents its bits most significant bit first. The receive path collects incoming bits most significant bit first. Each completed byte goes into the receive queue, which the host drains through a read port whose data is valid before the read strobe.

Each queue has a programmable threshold and a registered trigger output. The two triggers sense in opposite directions. The transmit trigger asks for more data while the queue runs low. The receive trigger asks for service once the queue holds more than the threshold. Each queue also has a clear input and a freeze input. Clear empties the queue, resets its shift register and drops the sticky error flag. Freeze makes hardware-side accesses have no effect and leaves the host side working.

Top module: `serial_byte_fifo_pair`

## Requirements
- R1: Bytes leave each queue in the order they entered: host writes reach the transmit shifter in order. Received bytes appear on `rx_rd_data`, which shows the oldest stored byte while the receive queue is not empty, in arrival order.
- R2: A host write while the transmit queue is full is dropped and sets `tx_ovf`. A host read while the receive queue is empty is dropped and sets `rx_unf`. Both flags stay set until their queue is cleared.
- R3: `tx_trig` equals 1 exactly when, in the previous clock cycle, `tx_count` was less than `tx_lvl`.
- R4: `rx_trig` equals 1 exactly when, in the previous clock cycle, `rx_count` was greater than `rx_lvl`.
- R5: A clear empties its queue and resets its shift register: `tx_sdo` goes to 0, or the receive bit count restarts at the first bit of a new byte. A clear also resets the sticky flag. It wins over any push, pop, load or shift in the same cycle.
- R6: While `tx_freeze` is 1, `tx_load` pops nothing and loads nothing. While `rx_freeze` is 1, a byte completed by the receive shifter is discarded and the queue is unchanged.
- R7: Freeze never blocks the host side. Host writes to the frozen transmit queue and host reads from the frozen receive queue take effect normally.
- R8: `tx_load` on a non-empty, unfrozen transmit queue pops the oldest byte into the shift register. `tx_sdo` is bit 7 of the shift register. Each `tx_shift` cycle without a load moves it left by one and fills with 0, so a byte appears MSB first.
- R9: Each `rx_shift` cycle shifts `rx_sdi` into the low end of the receive shift register. On the eighth such cycle since reset, clear or the previous byte, the byte whose first received bit is bit 7 is pushed into the receive queue.
- R10: Each count runs from 0 to 8. `full` is 1 exactly at 8 and `empty` is 1 exactly at 0. A push into a full queue and a pop from an empty one have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr_en | input | 1 | Host write strobe into the transmit queue |
| tx_wr_data | input | 8 | Host write byte |
| tx_lvl | input | 4 | Transmit trigger threshold |
| tx_clear | input | 1 | Empty transmit queue and shifter, reset `tx_ovf` |
| tx_freeze | input | 1 | Block hardware pops of the transmit queue |
| tx_load | input | 1 | Hardware request to pop a byte into the shifter |
| tx_shift | input | 1 | Shift the transmit register one bit |
| tx_sdo | output | 1 | Serial transmit bit (register MSB) |
| tx_count | output | 4 | Bytes held in the transmit queue |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_trig | output | 1 | Registered transmit trigger |
| tx_ovf | output | 1 | Sticky host write overflow |
| rx_rd_en | input | 1 | Host read strobe from the receive queue |
| rx_rd_data | output | 8 | Oldest byte in the receive queue |
| rx_lvl | input | 4 | Receive trigger threshold |
| rx_clear | input | 1 | Empty receive queue and shifter, reset `rx_unf` |
| rx_freeze | input | 1 | Block hardware pushes into the receive queue |
| rx_shift | input | 1 | Sample `rx_sdi` into the receive register |
| rx_sdi | input | 1 | Serial receive bit |
| rx_count | output | 4 | Bytes held in the receive queue |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_trig | output | 1 | Registered receive trigger |
| rx_unf | output | 1 | Sticky host read underflow |

## Verification
The assertions check the following on every cycle:
- each count stays within range;
- a clear empties its queue and silences the transmit output;
- the sticky flags set and hold;
- a frozen hardware side leaves the count alone, while host-side traffic still moves it;
- each trigger follows the previous cycle's count and threshold.

Only the bench's scenarios can show byte order end to end. This covers the MSB-first order at `tx_sdo` and the assembly of received bits into bytes. It also covers the loss of a byte completed under freeze and the exact reset values. The bench checks these against its own queue model, under directed corner cases and a long seeded random run.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  // Which side of a queue is driven by the hardware shifter.
  typedef enum logic {
    HW_POPS  = 1'b0,
    HW_PUSHES = 1'b1
  } hw_side_e;

  // Trigger rule: the receive direction fires above the threshold,
  // the transmit direction fires below it.
  function automatic logic trig_eval(input logic above,
                                     input int unsigned used,
                                     input int unsigned lvl);
    if (above) return (used > lvl);
    return (used < lvl);
  endfunction

  function automatic int unsigned ptr_inc(input int unsigned ptr,
                                          input int unsigned depth);
    if (ptr == depth - 1) return 0;
    return ptr + 1;
  endfunction

endpackage

// File: rtl/dbf_fifo.sv
module dbf_fifo #(
  parameter int               DATA_W  = 8,
  parameter int               DEPTH   = 8,
  parameter int               LVL_W   = 4,
  parameter int               CNT_W   = $clog2(DEPTH + 1),
  parameter dbf_pkg::hw_side_e HW_SIDE = dbf_pkg::HW_POPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              freeze,
  input  logic [LVL_W-1:0]  lvl,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_taken,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic              trig,
  output logic              err
);
  import dbf_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic ABOVE = (HW_SIDE == HW_PUSHES);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  count_q;
  logic              trig_q, err_q, past_ok;

  // Named events
  logic push_blk, pop_blk, err_evt, push_ok, pop_ok;

  assign full  = (count_q == FULL_CNT);
  assign empty = (count_q == '0);

  generate
    if (HW_SIDE == HW_POPS) begin : g_hw_pop
      assign push_blk = 1'b0;
      assign pop_blk  = freeze;
      assign err_evt  = push_req & full;
    end else begin : g_hw_push
      assign push_blk = freeze;
      assign pop_blk  = 1'b0;
      assign err_evt  = pop_req & empty;
    end
  endgenerate

  assign push_ok   = push_req & ~full  & ~push_blk & ~clear;
  assign pop_ok    = pop_req  & ~empty & ~pop_blk  & ~clear;
  assign pop_taken = pop_ok;
  assign pop_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count_q <= '0;
      err_q   <= 1'b0;
    end else if (clear) begin
      wptr    <= '0;
      rptr    <= '0;
      count_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (push_ok) wptr <= PTR_W'(ptr_inc(32'(wptr), DEPTH));
      if (pop_ok)  rptr <= PTR_W'(ptr_inc(32'(rptr), DEPTH));
      count_q <= count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
      if (err_evt) err_q <= 1'b1;
    end
  end

  // Trigger is registered from the current count and threshold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      trig_q  <= trig_eval(ABOVE, 32'(count_q), 32'(lvl));
      past_ok <= 1'b1;
    end
  end

  assign count = count_q;
  assign trig  = trig_q;
  assign err   = err_q;

  // R10: occupancy never leaves its range
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_CNT);

  // R5: clear empties the queue and drops the flag
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count_q == '0) && !err_q);

  // R2: overflow / underflow sets the sticky flag
  a_r2_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !clear) |=> err_q);

  // R2: the flag holds until a clear
  a_r2_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clear) |=> err_q);

  // R3 / R4: trigger reflects the previous cycle's count and threshold
  a_r3_r4_trig_lag: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (trig_q == trig_eval(ABOVE, 32'($past(count_q)), 32'($past(lvl)))));

  generate
    if (HW_SIDE == HW_POPS) begin : g_chk_pop
      // R6: frozen hardware pops leave the count unchanged
      a_r6_freeze_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !clear && !push_req) |=> $stable(count_q));
      // R7: host writes still land while frozen
      a_r7_host_write_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !clear && push_req && !full) |=> (count_q == $past(count_q) + 1'b1));
    end else begin : g_chk_push
      // R6: frozen hardware pushes leave the count unchanged
      a_r6_freeze_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !clear && !pop_req) |=> $stable(count_q));
      // R7: host reads still drain while frozen
      a_r7_host_read_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !clear && pop_req && !empty) |=> (count_q == $past(count_q) - 1'b1));
    end
  endgenerate

endmodule

// File: rtl/dbf_tx_shift.sv
module dbf_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  output logic              sdo
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_q <= '0;
    else if (clear)  sh_q <= '0;
    else if (load)   sh_q <= load_data;
    else if (shift)  sh_q <= {sh_q[DATA_W-2:0], 1'b0};
  end

  assign sdo = sh_q[DATA_W-1];

  // R8: a load puts the byte's MSB on the line next cycle
  a_r8_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> (sdo == $past(load_data[DATA_W-1])));

  // R5: clear silences the transmit line
  a_r5_clear_sdo: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !sdo);

endmodule

// File: rtl/dbf_rx_shift.sv
module dbf_rx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift,
  input  logic              sdi,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_data
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [BIT_W-1:0]  bits_q;

  assign byte_data = {sh_q[DATA_W-2:0], sdi};
  assign byte_done = shift & ~clear & (bits_q == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bits_q <= '0;
    end else if (clear) begin
      sh_q   <= '0;
      bits_q <= '0;
    end else if (shift) begin
      sh_q   <= byte_data;
      bits_q <= (bits_q == LAST_BIT) ? '0 : bits_q + 1'b1;
    end
  end

  // R9: completed bytes are at least a full frame apart
  a_r9_frame_gap: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

  // R5: clear restarts bit collection
  a_r5_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (bits_q == '0));

endmodule

// File: rtl/serial_byte_fifo_pair.sv
module serial_byte_fifo_pair #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int LVL_W  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr_en,
  input  logic [DATA_W-1:0] tx_wr_data,
  input  logic [LVL_W-1:0]  tx_lvl,
  input  logic              tx_clear,
  input  logic              tx_freeze,
  input  logic              tx_load,
  input  logic              tx_shift,
  output logic              tx_sdo,
  output logic [CNT_W-1:0]  tx_count,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              tx_trig,
  output logic              tx_ovf,
  input  logic              rx_rd_en,
  output logic [DATA_W-1:0] rx_rd_data,
  input  logic [LVL_W-1:0]  rx_lvl,
  input  logic              rx_clear,
  input  logic              rx_freeze,
  input  logic              rx_shift,
  input  logic              rx_sdi,
  output logic [CNT_W-1:0]  rx_count,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_trig,
  output logic              rx_unf
);
  logic [DATA_W-1:0] tx_pop_data;
  logic              tx_pop_taken;
  logic              rx_byte_done;
  logic [DATA_W-1:0] rx_byte_data;
  logic              rx_pop_taken;

  dbf_fifo #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W),
    .HW_SIDE(dbf_pkg::HW_POPS)
  ) u_tx_q (
    .clk(clk), .rst_n(rst_n), .clear(tx_clear), .freeze(tx_freeze), .lvl(tx_lvl),
    .push_req(tx_wr_en), .push_data(tx_wr_data),
    .pop_req(tx_load), .pop_data(tx_pop_data), .pop_taken(tx_pop_taken),
    .count(tx_count), .full(tx_full), .empty(tx_empty), .trig(tx_trig), .err(tx_ovf)
  );

  dbf_tx_shift #(.DATA_W(DATA_W)) u_tx_sh (
    .clk(clk), .rst_n(rst_n), .clear(tx_clear),
    .load(tx_pop_taken), .load_data(tx_pop_data), .shift(tx_shift), .sdo(tx_sdo)
  );

  dbf_rx_shift #(.DATA_W(DATA_W)) u_rx_sh (
    .clk(clk), .rst_n(rst_n), .clear(rx_clear), .shift(rx_shift), .sdi(rx_sdi),
    .byte_done(rx_byte_done), .byte_data(rx_byte_data)
  );

  dbf_fifo #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W),
    .HW_SIDE(dbf_pkg::HW_PUSHES)
  ) u_rx_q (
    .clk(clk), .rst_n(rst_n), .clear(rx_clear), .freeze(rx_freeze), .lvl(rx_lvl),
    .push_req(rx_byte_done), .push_data(rx_byte_data),
    .pop_req(rx_rd_en), .pop_data(rx_rd_data), .pop_taken(rx_pop_taken),
    .count(rx_count), .full(rx_full), .empty(rx_empty), .trig(rx_trig), .err(rx_unf)
  );

  // R8: the shifter is only loaded from a queue that held data
  a_r8_load_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_taken |-> !tx_empty && !tx_freeze);

  // R2: a host read from an empty receive queue is never taken
  a_r2_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_taken |-> !rx_empty);

endmodule

// File: tb/test_serial_byte_fifo_pair.sv
module test_serial_byte_fifo_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_wr_en = 0, tx_clear = 0, tx_freeze = 0, tx_load = 0, tx_shift = 0;
  logic [7:0] tx_wr_data = 0;
  logic [3:0] tx_lvl = 0, rx_lvl = 0;
  logic       rx_rd_en = 0, rx_clear = 0, rx_freeze = 0, rx_shift = 0, rx_sdi = 0;
  logic       tx_sdo, tx_full, tx_empty, tx_trig, tx_ovf;
  logic       rx_full, rx_empty, rx_trig, rx_unf;
  logic [3:0] tx_count, rx_count;
  logic [7:0] rx_rd_data;

  always #10 clk = ~clk;

  serial_byte_fifo_pair i_serial_byte_fifo_pair (
    .clk(clk), .rst_n(rst_n),
    .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_lvl(tx_lvl),
    .tx_clear(tx_clear), .tx_freeze(tx_freeze), .tx_load(tx_load), .tx_shift(tx_shift),
    .tx_sdo(tx_sdo), .tx_count(tx_count), .tx_full(tx_full), .tx_empty(tx_empty),
    .tx_trig(tx_trig), .tx_ovf(tx_ovf),
    .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_lvl(rx_lvl),
    .rx_clear(rx_clear), .rx_freeze(rx_freeze), .rx_shift(rx_shift), .rx_sdi(rx_sdi),
    .rx_count(rx_count), .rx_full(rx_full), .rx_empty(rx_empty),
    .rx_trig(rx_trig), .rx_unf(rx_unf)
  );

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  string ctag = "R1";

  // Reference model state
  logic [7:0] txq[$], rxq[$];
  bit         tx_ovf_m = 0, rx_unf_m = 0, tx_trig_m = 0, rx_trig_m = 0;
  logic [7:0] tx_sh_m = 0, rx_sh_m = 0;
  int         rx_bits_m = 0;

  function automatic bit want_tx_trig(int used, int lvl); return used < lvl; endfunction
  function automatic bit want_rx_trig(int used, int lvl); return lvl < used; endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(ctag,  "tx_count", tx_count, txq.size());
    chk("R10", "tx_full",  tx_full,  txq.size() == 8);
    chk("R10", "tx_empty", tx_empty, txq.size() == 0);
    chk("R3",  "tx_trig",  tx_trig,  tx_trig_m);
    chk("R2",  "tx_ovf",   tx_ovf,   tx_ovf_m);
    chk("R8",  "tx_sdo",   tx_sdo,   tx_sh_m[7]);
    chk(ctag,  "rx_count", rx_count, rxq.size());
    chk("R10", "rx_full",  rx_full,  rxq.size() == 8);
    chk("R10", "rx_empty", rx_empty, rxq.size() == 0);
    chk("R4",  "rx_trig",  rx_trig,  rx_trig_m);
    chk("R2",  "rx_unf",   rx_unf,   rx_unf_m);
    if (rxq.size() > 0) chk("R1", "rx_rd_data", rx_rd_data, rxq[0]);
  endtask

  // One clock: predict, take the edge, compare at the falling edge.
  task automatic step();
    int ts, rs;
    bit ntt, nrt, tpop, tpush, rpop, rpush;
    logic [7:0] nb, popped;
    ts = txq.size(); rs = rxq.size();
    ntt = want_tx_trig(ts, tx_lvl);
    nrt = want_rx_trig(rs, rx_lvl);
    @(posedge clk);
    tx_trig_m = ntt; rx_trig_m = nrt;
    if (tx_clear) begin
      txq.delete(); tx_ovf_m = 0; tx_sh_m = 0;
    end else begin
      tpop  = tx_load && !tx_freeze && ts > 0;
      tpush = tx_wr_en && ts < 8;
      if (tx_wr_en && ts == 8) tx_ovf_m = 1;
      if (tpop) begin popped = txq.pop_front(); tx_sh_m = popped; end
      else if (tx_shift) tx_sh_m = {tx_sh_m[6:0], 1'b0};
      if (tpush) txq.push_back(tx_wr_data);
    end
    if (rx_clear) begin
      rxq.delete(); rx_unf_m = 0; rx_sh_m = 0; rx_bits_m = 0;
    end else begin
      rpop = rx_rd_en && rs > 0;
      if (rx_rd_en && rs == 0) rx_unf_m = 1;
      rpush = 0; nb = 0;
      if (rx_shift) begin
        nb = {rx_sh_m[6:0], rx_sdi};
        if (rx_bits_m == 7) begin rpush = !rx_freeze && rs < 8; rx_bits_m = 0; end
        else rx_bits_m++;
        rx_sh_m = nb;
      end
      if (rpop) void'(rxq.pop_front());
      if (rpush) rxq.push_back(nb);
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    tx_wr_en = 0; tx_clear = 0; tx_load = 0; tx_shift = 0;
    rx_rd_en = 0; rx_clear = 0; rx_shift = 0;
  endtask

  task automatic send_rx(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      rx_shift = 1; rx_sdi = b[i]; step();
    end
    rx_shift = 0;
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : stim
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // Reset state
    chk("R10", "reset tx_empty", tx_empty, 1);
    chk("R10", "reset rx_empty", rx_empty, 1);
    chk("R3",  "reset tx_trig",  tx_trig,  0);
    chk("R8",  "reset tx_sdo",   tx_sdo,   0);
    rst_n = 1;
    tx_lvl = 4'd3; rx_lvl = 4'd1;

    // R1/R8: write bytes, load and shift them out MSB first
    ctag = "R1";
    for (int i = 0; i < 5; i++) begin
      tx_wr_en = 1; tx_wr_data = 8'hA0 + 8'(i * 17); step();
    end
    idle();
    for (int b = 0; b < 5; b++) begin
      tx_load = 1; step(); tx_load = 0;
      tx_shift = 1; repeat (8) step(); tx_shift = 0;
    end

    // R2/R10: fill and overflow the transmit queue
    ctag = "R2";
    for (int i = 0; i < 10; i++) begin
      tx_wr_en = 1; tx_wr_data = 8'(i + 1); step();
    end
    idle();
    // R5: clear wins over a same-cycle write and load
    ctag = "R5";
    tx_clear = 1; tx_wr_en = 1; tx_load = 1; tx_wr_data = 8'h55; step();
    idle(); step();

    // R9/R1: receive three bytes, then read them
    ctag = "R9";
    send_rx(8'hC3); send_rx(8'h5A); send_rx(8'h81);
    ctag = "R1";
    rx_rd_en = 1; repeat (3) step();
    // R2: read from an empty receive queue
    ctag = "R2";
    step(); rx_rd_en = 0; step();

    // R6/R7: freeze the hardware sides, host keeps working
    ctag = "R6";
    tx_wr_en = 1; tx_wr_data = 8'h3C; step(); step(); tx_wr_en = 0;
    tx_freeze = 1; tx_load = 1; repeat (3) step(); tx_load = 0;
    ctag = "R7";
    tx_wr_en = 1; tx_wr_data = 8'h99; step(); tx_wr_en = 0;
    tx_freeze = 0;
    ctag = "R6";
    send_rx(8'h42);
    rx_freeze = 1; send_rx(8'hFF);
    ctag = "R7";
    rx_rd_en = 1; step(); rx_rd_en = 0;
    rx_freeze = 0;
    // R5: clear mid-byte restarts receive bit count
    ctag = "R5";
    rx_shift = 1; rx_sdi = 1; repeat (3) step();
    idle(); rx_clear = 1; rx_shift = 1; step(); rx_clear = 0; rx_shift = 0;
    send_rx(8'h6E);
    idle(); tx_clear = 1; rx_clear = 1; step(); idle(); step();

    // Random phase
    ctag = "R1";
    for (int n = 0; n < 6000; n++) begin
      tx_wr_en   = ($urandom_range(0, 99) < 40);
      tx_wr_data = 8'($urandom);
      tx_load    = ($urandom_range(0, 99) < 30);
      tx_shift   = ($urandom_range(0, 99) < 60);
      tx_clear   = ($urandom_range(0, 99) < 2);
      tx_freeze  = ($urandom_range(0, 99) < 8);
      rx_shift   = ($urandom_range(0, 99) < 85);
      rx_sdi     = 1'($urandom);
      rx_rd_en   = ($urandom_range(0, 99) < 8);
      rx_clear   = ($urandom_range(0, 99) < 1);
      rx_freeze  = ($urandom_range(0, 99) < 8);
      if ($urandom_range(0, 99) < 5) tx_lvl = 4'($urandom);
      if ($urandom_range(0, 99) < 5) rx_lvl = 4'($urandom);
      step();
    end
    idle(); tx_freeze = 0; rx_freeze = 0; step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule